// File: doc/BRIEF.md
# IrDA Low-Power Pulse Timing Unit

This block supplies the pulse timing for the low-power mode of an infrared serial encoder and decoder. It divides the system clock by a programmable 8-bit divisor to make a single-cycle strobe that stands in for a low-power 16x baud clock. The transmit side turns each request for an encoded zero bit into one pulse whose width is exactly three strobe periods. Pulse width therefore depends on the divisor and not on the bit period. The receive side synchronizes the raw infrared line and rejects any pulse that does not stay high for a full strobe period.

A divisor of zero is illegal and stops the strobe entirely. While the divisor is zero, no transmit pulse is ever emitted and the cleaned receive output stays low. Software should choose the divisor so that the strobe falls between about 1.42 MHz and 2.12 MHz. That range gives transmit pulses of roughly 1.41 to 2.11 microseconds, and it rejects receive glitches that are shorter than one strobe period.

Top module: `irlp_pulse_timer`

## Requirements
- R1: After reset the divisor reads as zero, and both `tx_pulse` and `rx_clean` are low.
- R2: With a divisor N from 1 to 255, the strobe fires once every N clock cycles. A divisor write reloads the down-counter in the cycle after the write, so the first strobe at the new rate comes N cycles after that write edge.
- R3: While the divisor is zero, no strobe occurs and `tx_pulse` stays low whatever requests arrive.
- R4: Transmit timing has three parts:
  - A request starts a pulse at the first strobe in the same cycle as the request or in a later cycle.
  - `tx_pulse` then stays high for exactly three strobe periods, which is 3N cycles at a constant divisor.
  - `tx_pulse` changes only on clock edges where the strobe is active.
- R5: A request that arrives while a pulse is active, or while a request is already waiting, is held as a single pending request. It starts a new pulse at the first strobe after the current pulse ends, so pulses never overlap or lengthen.
- R6: Receive filtering works as follows:
  - `rx_line` passes through a two-flop synchronizer.
  - `rx_clean` rises on the edge where the synchronized line has been high for N consecutive cycles.
  - `rx_clean` falls on the edge after the synchronized line returns low.
  - A high pulse shorter than N cycles never raises `rx_clean`.
- R7: While the divisor is zero, `rx_clean` stays low.
- R8: A request made while the divisor is zero stays pending. It is sent as a pulse at the first strobe after a nonzero divisor is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| div_wr | input | 1 | Divisor write strobe |
| div_wdata | input | 8 | New divisor value; 0 stops the strobe |
| tx_req | input | 1 | One-cycle request to send one low-power pulse |
| rx_line | input | 1 | Raw receive line, active high |
| tx_pulse | output | 1 | Infrared transmit pulse, active high |
| rx_clean | output | 1 | Filtered receive pulse, active high |

## Verification
The transmit path is tried three ways: with isolated requests, with requests packed inside a running pulse, and with requests made under a zero divisor. These patterns separate the correct width from a stretched pulse, a held request from a lost one, and a dead strobe from one that still counts. The receive path is driven with high pulses of length N-1, N and well beyond N. These lengths locate the acceptance threshold exactly, one cycle either side. A long random phase then mixes divisor rewrites (including zero), sparse requests and a toggling receive line, so that immediate reload and the pending logic are tried at arbitrary counter phases.

// File: rtl/irlp_pkg.sv
package irlp_pkg;

  typedef enum logic {
    TX_IDLE   = 1'b0,
    TX_ACTIVE = 1'b1
  } tx_state_e;

endpackage

// File: rtl/irlp_rst_sync.sv
module irlp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/irlp_strobe_gen.sv
module irlp_strobe_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  output logic [DIV_W-1:0] div_q,
  output logic             strobe
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] div_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             div_live;

  assign div_live = (div_q != '0);

  // a write reloads the counter at once; otherwise count down and reload at one
  always_comb begin
    div_d = div_q;
    cnt_d = cnt_q;
    if (div_wr) begin
      div_d = div_wdata;
      cnt_d = div_wdata;
    end else if (div_live) begin
      if (cnt_q <= ONE) begin
        cnt_d = div_q;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end

  assign strobe = div_live && (cnt_q == ONE);

endmodule

// File: rtl/irlp_tx_shaper.sv
module irlp_tx_shaper
  import irlp_pkg::*;
#(
  parameter int PULSE_STROBES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic tx_req,
  output logic tx_pulse
);

  localparam int CNT_W = (PULSE_STROBES > 1) ? $clog2(PULSE_STROBES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_STROBES - 1);

  tx_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             start;

  assign start = (state_q == TX_IDLE) && strobe && (pend_q || tx_req);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pend_d  = pend_q | tx_req;
    case (state_q)
      TX_IDLE: begin
        if (start) begin
          state_d = TX_ACTIVE;
          cnt_d   = '0;
          pend_d  = 1'b0;
        end
      end
      TX_ACTIVE: begin
        if (strobe) begin
          if (cnt_q == LAST) begin
            state_d = TX_IDLE;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
    end
  end

  assign tx_pulse = (state_q == TX_ACTIVE);

endmodule

// File: rtl/irlp_rx_filter.sv
module irlp_rx_filter #(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_q,
  input  logic             rx_line,
  output logic             rx_sync,
  output logic             rx_clean
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [DIV_W-1:0]       run_q, run_d;
  logic                   clean_d;
  logic                   clean_q;
  logic [DIV_W:0]         run_next_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], rx_line};
    end
  end

  assign rx_sync    = sync_q[SYNC_STAGES-1];
  assign run_next_w = {1'b0, run_q} + (DIV_W+1)'(1);

  // count consecutive high cycles (saturating) and accept at one strobe period
  always_comb begin
    if (!rx_sync) begin
      run_d = '0;
    end else if (run_q == '1) begin
      run_d = run_q;
    end else begin
      run_d = run_q + DIV_W'(1);
    end
    clean_d = rx_sync && (div_q != '0) && (run_next_w >= {1'b0, div_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      clean_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      clean_q <= clean_d;
    end
  end

  assign rx_clean = clean_q;

endmodule

// File: rtl/irlp_pulse_timer.sv
module irlp_pulse_timer #(
  parameter int DIV_W         = 8,
  parameter int PULSE_STROBES = 3,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic             tx_req,
  input  logic             rx_line,
  output logic             tx_pulse,
  output logic             rx_clean
);

  logic             rst_n_int;
  logic             strobe;
  logic [DIV_W-1:0] div_q;
  logic             rx_sync;

  irlp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  irlp_strobe_gen #(.DIV_W(DIV_W)) u_strobe (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .div_wr    (div_wr),
    .div_wdata (div_wdata),
    .div_q     (div_q),
    .strobe    (strobe)
  );

  irlp_tx_shaper #(.PULSE_STROBES(PULSE_STROBES)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .strobe   (strobe),
    .tx_req   (tx_req),
    .tx_pulse (tx_pulse)
  );

  irlp_rx_filter #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .div_q    (div_q),
    .rx_line  (rx_line),
    .rx_sync  (rx_sync),
    .rx_clean (rx_clean)
  );

endmodule

// File: rtl/irlp_checker.sv
module irlp_checker #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             strobe,
  input logic [DIV_W-1:0] div_q,
  input logic             rx_sync,
  input logic             tx_pulse,
  input logic             rx_clean
);

  // R3: a zero divisor never lets the strobe fire
  a_r3_zero_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0) |-> !strobe);

  // R4: the transmit pulse only moves on strobe edges
  a_r4_tx_moves_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(tx_pulse));

  // R6: a low synchronized line drops the cleaned output next cycle
  a_r6_rx_low_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_sync |=> !rx_clean);

  // R7: no receive output while the divisor is zero
  a_r7_rx_dead_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0) |=> !rx_clean);

endmodule

bind irlp_pulse_timer irlp_checker #(.DIV_W(DIV_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .strobe   (strobe),
  .div_q    (div_q),
  .rx_sync  (rx_sync),
  .tx_pulse (tx_pulse),
  .rx_clean (rx_clean)
);

// File: tb/tb_irlp_pulse_timer.sv
module tb_irlp_pulse_timer;

  logic       clk;
  logic       rst_n;
  logic       div_wr;
  logic [7:0] div_wdata;
  logic       tx_req;
  logic       rx_line;
  logic       tx_pulse;
  logic       rx_clean;

  int    n_checks;
  int    n_fail;
  bit    done;
  string cur_req;

  irlp_pulse_timer dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_wr    (div_wr),
    .div_wdata (div_wdata),
    .tx_req    (tx_req),
    .rx_line   (rx_line),
    .tx_pulse  (tx_pulse),
    .rx_clean  (rx_clean)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int m_div, m_phase, m_left, m_high;
  bit m_pend, m_rx, m_s1, m_s2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_phase = 0; m_left = 0; m_high = 0;
      m_pend = 0; m_rx = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      bit stb;
      stb = (m_div != 0) && (m_phase == m_div - 1);
      if (m_left == 0) begin
        if (stb && (m_pend || tx_req)) begin
          m_left = 3;
          m_pend = 0;
        end else begin
          m_pend = m_pend || tx_req;
        end
      end else begin
        m_pend = m_pend || tx_req;
        if (stb) m_left--;
      end
      m_rx   = m_s2 && (m_div != 0) && (m_high + 1 >= m_div);
      m_high = m_s2 ? m_high + 1 : 0;
      m_s2   = m_s1;
      m_s1   = rx_line;
      if (div_wr) begin
        m_div   = div_wdata;
        m_phase = 0;
      end else if (stb) begin
        m_phase = 0;
      end else if (m_div != 0) begin
        m_phase++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, tx_pulse, (m_left > 0) ? 1 : 0);
      check(cur_req, rx_clean, m_rx ? 1 : 0);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_div(input int v);
    div_wr = 1'b1; div_wdata = 8'(v);
    @(negedge clk);
    div_wr = 1'b0;
  endtask

  task automatic request();
    tx_req = 1'b1;
    @(negedge clk);
    tx_req = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int width, seen, wait_n;
    n_checks = 0; n_fail = 0; done = 0;
    cur_req = "R1";
    div_wr = 0; div_wdata = 0; tx_req = 0; rx_line = 0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    check("R1", tx_pulse, 0);
    check("R1", rx_clean, 0);

    // zero divisor: request held, no pulse, no receive output
    cur_req = "R3";
    request();
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      if (tx_pulse) seen = 1;
      @(negedge clk);
    end
    check("R3", seen, 0);
    cur_req = "R7";
    rx_line = 1'b1;
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (rx_clean) seen = 1;
    end
    check("R7", seen, 0);
    rx_line = 1'b0;
    idle(4);

    // pending request fires once a divisor is written
    cur_req = "R8";
    write_div(3);
    wait_n = 0;
    while (!tx_pulse && wait_n < 10) begin
      @(negedge clk);
      wait_n++;
    end
    check("R8", tx_pulse, 1);
    idle(20);

    // pulse width = 3 strobe periods
    cur_req = "R4";
    write_div(4);
    idle(3);
    request();
    while (!tx_pulse) @(negedge clk);
    width = 0;
    while (tx_pulse) begin
      width++;
      @(negedge clk);
    end
    check("R4", width, 12);
    idle(10);

    // requests during a pulse: one held, no stretch
    cur_req = "R5";
    request();
    idle(5);
    request();
    idle(2);
    request();
    idle(40);
    write_div(1);
    request();
    request();
    idle(12);

    // immediate reload mid-count
    cur_req = "R2";
    write_div(7);
    idle(3);
    write_div(5);
    request();
    idle(30);
    write_div(2);
    request();
    idle(20);

    // receive threshold at N-1, N, long
    cur_req = "R6";
    write_div(6);
    rx_line = 1'b1; idle(5); rx_line = 1'b0;
    seen = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (rx_clean) seen = 1;
    end
    check("R6", seen, 0);
    rx_line = 1'b1; idle(6); rx_line = 1'b0;
    seen = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (rx_clean) seen = 1;
    end
    check("R6", seen, 1);
    rx_line = 1'b1; idle(20); rx_line = 1'b0;
    idle(10);
    check("R6", rx_clean, 0);

    // random mix, compared against the model every cycle
    cur_req = "R5";
    for (int i = 0; i < 6000; i++) begin
      div_wr    = ($urandom % 150) == 0;
      div_wdata = 8'($urandom % 8);
      tx_req    = ($urandom % 15) == 0;
      if (($urandom % 6) == 0) rx_line = ~rx_line;
      @(negedge clk);
    end
    div_wr = 0; tx_req = 0; rx_line = 0;
    idle(50);
    finish_run();
  end

endmodule